// File: doc/BRIEF.md
# Prescaled PWM Timer Channel

This block is one timer channel that turns a programmable count into a pulse-width-modulated output. The input clock is first divided by a prescaler to make a counting tick. A counter then runs over a programmable period, and the count is compared against a programmable threshold to set the output level. The count either ramps up and wraps (edge-aligned) or ramps up and back down (center-aligned). Two polarity modes select whether the output is high or low while the count sits below the threshold.

Configuration arrives through five write strobes, each with its own data field. Each write lands in a staging register. The value the channel actually runs with is held in a shadow copy. That copy is refreshed only at a period boundary, so a single PWM cycle never mixes two configurations. While the channel is disabled, the shadow copy follows the staging registers. A one-clock update pulse marks every period boundary, so a controller can pace its next duty-cycle write.

Top module: `pwm_timer_chan`

## Requirements
- R1: The counter advances once every (prescaler + 1) clock cycles. The first step comes (prescaler + 1) cycles after the enable rises.
- R2: In edge-aligned counting (alignment value 0), the count runs 0, 1, …, period and then returns to 0. One PWM cycle is therefore (period + 1) ticks, and the count never exceeds the active period.
- R3: In polarity mode value 0, the output is high when the count is below the compare value and low otherwise.
- R4: In polarity mode value 1, the output is low when the count is below the compare value and high otherwise.
- R5: A compare value of 0 keeps the output at its inactive level for the whole cycle. A compare value above the period keeps it at the active level for the whole cycle.
- R6: In center-aligned counting (alignment value 1), the count rises from 0 to the period and falls back to 1. The boundary comes when the count returns to 0, so one cycle lasts 2 × period ticks. A period of 0 makes every tick a boundary with the count held at 0.
- R7: Writes go to staging registers. They become active at the clock edge of the next period boundary (the wrap in edge mode, the return to 0 in center mode). While the channel is disabled, they become active on the edge after the write.
- R8: `update_pulse` is high for the one clock cycle that follows each boundary edge. In that cycle the count reads 0.
- R9: With `en` low, the prescaler and counter are held at 0 and no update pulse is started. The output shows the inactive level of the active polarity: 0 for mode 0, 1 for mode 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Channel run enable |
| wr_presc | input | 1 | Strobe: load `presc_data` into staging |
| presc_data | input | 16 | Prescaler value (divide by value + 1) |
| wr_period | input | 1 | Strobe: load `period_data` into staging |
| period_data | input | 16 | Period (top count) value |
| wr_compare | input | 1 | Strobe: load `compare_data` into staging |
| compare_data | input | 16 | Compare threshold |
| wr_mode | input | 1 | Strobe: load `mode_data` into staging |
| mode_data | input | 1 | Polarity mode: 0 high-below, 1 low-below |
| wr_align | input | 1 | Strobe: load `align_data` into staging |
| align_data | input | 1 | Counting: 0 edge-aligned, 1 center-aligned |
| pwm_out | output | 1 | PWM output |
| update_pulse | output | 1 | One-cycle pulse after each period boundary |

## Verification
The assertions assume that reset is applied at start-up and that all inputs are two-state from then on. They also assume that `en` is the only thing that can clear the count outside a boundary. The count-range and shadow-hold properties rely on configuration reaching the active copy only while disabled or at a boundary.

The stimulus drives every strobe and data field one nanosecond after a rising edge. Each full reconfiguration is done with the channel disabled. Mid-run writes touch only the compare value, so the expected waveform can be predicted from the tick index alone.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int TMR_W = 16;

    typedef logic [TMR_W-1:0] tmr_t;

    typedef enum logic {
        POL_HIGH_BELOW = 1'b0,
        POL_LOW_BELOW  = 1'b1
    } pol_e;

    typedef enum logic {
        CNT_EDGE   = 1'b0,
        CNT_CENTER = 1'b1
    } algn_e;

    typedef struct packed {
        tmr_t  presc;
        tmr_t  period;
        tmr_t  cmp;
        pol_e  pol;
        algn_e algn;
    } tmr_cfg_t;

    localparam tmr_cfg_t CFG_RESET = '{
        presc:  '0,
        period: '0,
        cmp:    '0,
        pol:    POL_HIGH_BELOW,
        algn:   CNT_EDGE
    };

    // Map "count is below threshold" to the pin level for a polarity.
    function automatic logic drive_level(pol_e pol, logic below);
        return (pol == POL_HIGH_BELOW) ? below : ~below;
    endfunction

endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_timer_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en,
    input  logic     bnd,
    input  logic     wr_presc,
    input  tmr_t     presc_data,
    input  logic     wr_period,
    input  tmr_t     period_data,
    input  logic     wr_compare,
    input  tmr_t     compare_data,
    input  logic     wr_mode,
    input  pol_e     mode_data,
    input  logic     wr_align,
    input  algn_e    align_data,
    output tmr_cfg_t active_cfg
);

    tmr_cfg_t stage_q;
    tmr_cfg_t shadow_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= CFG_RESET;
        end else begin
            if (wr_presc)   stage_q.presc  <= presc_data;
            if (wr_period)  stage_q.period <= period_data;
            if (wr_compare) stage_q.cmp    <= compare_data;
            if (wr_mode)    stage_q.pol    <= mode_data;
            if (wr_align)   stage_q.algn   <= align_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= CFG_RESET;
        end else if (!en || bnd) begin
            shadow_q <= stage_q;
        end
    end

    assign active_cfg = shadow_q;

    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !bnd) |=> $stable(shadow_q)); // R7

endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  tmr_t presc,
    output logic tick
);

    tmr_t div_q;

    assign tick = en && (div_q >= presc);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            div_q <= '0;
        end else if (tick) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + tmr_t'(1);
        end
    end

endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
    import pwm_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  tick,
    input  tmr_t  period,
    input  algn_e algn,
    output tmr_t  cnt,
    output logic  bnd,
    output logic  upd
);

    tmr_t cnt_q, cnt_nx;
    logic down_q, down_nx;
    logic upd_q;

    always_comb begin
        cnt_nx  = cnt_q;
        down_nx = down_q;
        bnd     = 1'b0;
        if (tick) begin
            if (algn == CNT_EDGE) begin
                down_nx = 1'b0;
                if (cnt_q >= period) begin
                    cnt_nx = '0;
                    bnd    = 1'b1;
                end else begin
                    cnt_nx = cnt_q + tmr_t'(1);
                end
            end else if (down_q || (cnt_q >= period)) begin
                if (cnt_q <= tmr_t'(1)) begin
                    cnt_nx  = '0;
                    down_nx = 1'b0;
                    bnd     = 1'b1;
                end else begin
                    cnt_nx  = cnt_q - tmr_t'(1);
                    down_nx = 1'b1;
                end
            end else begin
                cnt_nx = cnt_q + tmr_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
            upd_q  <= 1'b0;
        end else begin
            cnt_q  <= cnt_nx;
            down_q <= down_nx;
            upd_q  <= bnd;
        end
    end

    assign cnt = cnt_q;
    assign upd = upd_q;

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= period); // R2

    AST_CNT_WAITS_TICK: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(cnt_q)); // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        !en |=> (cnt_q == '0) && !upd_q); // R9

    AST_UPD_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        upd_q |-> (cnt_q == '0)); // R8

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_presc,
    input  logic [TMR_W-1:0]  presc_data,
    input  logic              wr_period,
    input  logic [TMR_W-1:0]  period_data,
    input  logic              wr_compare,
    input  logic [TMR_W-1:0]  compare_data,
    input  logic              wr_mode,
    input  logic              mode_data,
    input  logic              wr_align,
    input  logic              align_data,
    output logic              pwm_out,
    output logic              update_pulse
);

    tmr_cfg_t cfg;
    logic     tick;
    logic     bnd;
    tmr_t     cnt;

    pwm_shadow_regs u_regs (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .bnd          (bnd),
        .wr_presc     (wr_presc),
        .presc_data   (presc_data),
        .wr_period    (wr_period),
        .period_data  (period_data),
        .wr_compare   (wr_compare),
        .compare_data (compare_data),
        .wr_mode      (wr_mode),
        .mode_data    (pol_e'(mode_data)),
        .wr_align     (wr_align),
        .align_data   (algn_e'(align_data)),
        .active_cfg   (cfg)
    );

    pwm_prescaler u_presc (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .presc (cfg.presc),
        .tick  (tick)
    );

    pwm_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .tick   (tick),
        .period (cfg.period),
        .algn   (cfg.algn),
        .cnt    (cnt),
        .bnd    (bnd),
        .upd    (update_pulse)
    );

    // R3 R4 R5: below-threshold test mapped through polarity; R9 idle level
    assign pwm_out = en ? drive_level(cfg.pol, cnt < cfg.cmp)
                        : drive_level(cfg.pol, 1'b0);

endmodule

// File: tb/pwm_timer_chan_bench.sv
module pwm_timer_chan_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        en;
    logic        wr_presc, wr_period, wr_compare, wr_mode, wr_align;
    logic [15:0] presc_data, period_data, compare_data;
    logic        mode_data, align_data;
    logic        pwm_out, update_pulse;

    always #4 clk = ~clk;

    pwm_timer_chan u_pwm_timer_chan (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .wr_presc     (wr_presc),
        .presc_data   (presc_data),
        .wr_period    (wr_period),
        .period_data  (period_data),
        .wr_compare   (wr_compare),
        .compare_data (compare_data),
        .wr_mode      (wr_mode),
        .mode_data    (mode_data),
        .wr_align     (wr_align),
        .align_data   (align_data),
        .pwm_out      (pwm_out),
        .update_pulse (update_pulse)
    );

    typedef struct {
        logic  o;
        logic  u;
        bit    chk_u;
        string tag;
    } exp_t;

    exp_t sbq[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // Monitor: one expected item per checked cycle, compared mid-cycle.
    always @(negedge clk) begin
        exp_t e;
        if (sbq.size() > 0) begin
            e = sbq.pop_front();
            n_chk++;
            if (pwm_out !== e.o) begin
                n_bad++;
                $display("FAIL %s pwm_out actual=%b expected=%b", e.tag, pwm_out, e.o);
            end
            if (e.chk_u) begin
                n_chk++;
                if (update_pulse !== e.u) begin
                    n_bad++;
                    $display("FAIL %s update_pulse actual=%b expected=%b",
                             e.tag, update_pulse, e.u);
                end
            end
        end
    end

    // Count value at tick index t, from the counting rules (R2, R6).
    function automatic int exp_count(int t, int per, int algn);
        int len;
        int ph;
        if (algn == 0) return t % (per + 1);
        len = (per == 0) ? 1 : 2 * per;
        ph  = t % len;
        return (ph <= per) ? ph : len - ph;
    endfunction

    function automatic bit is_wrap(int t, int per, int algn);
        int len;
        if (t == 0) return 1'b0;
        len = (algn == 0) ? per + 1 : ((per == 0) ? 1 : 2 * per);
        return (t % len) == 0;
    endfunction

    task automatic run(int p, int per, int cmp, int mode, int algn, int n,
                       int jw, int newcmp, string tag);
        int cur_cmp = cmp;
        @(posedge clk); #1;
        wr_presc = 1; presc_data = 16'(p);
        wr_period = 1; period_data = 16'(per);
        wr_compare = 1; compare_data = 16'(cmp);
        wr_mode = 1; mode_data = mode[0];
        wr_align = 1; align_data = algn[0];
        @(posedge clk); #1;
        wr_presc = 0; wr_period = 0; wr_compare = 0; wr_mode = 0; wr_align = 0;
        @(posedge clk); #1;
        en = 1;
        for (int k = 0; k < n; k++) begin
            int   t = k / (p + 1);
            bit   b = ((k % (p + 1)) == 0) && is_wrap(t, per, algn);
            int   c;
            logic o;
            if (jw >= 0 && k >= jw + 2 && b) cur_cmp = newcmp;
            if (k == jw) begin
                wr_compare = 1; compare_data = 16'(newcmp);
            end else if (k == jw + 1) begin
                wr_compare = 0;
            end
            c = exp_count(t, per, algn);
            o = (mode == 0) ? (c < cur_cmp) : !(c < cur_cmp);
            sbq.push_back('{o, b, 1'b1, tag});
            @(posedge clk); #1;
        end
        wr_compare = 0;
        en = 0;
        sbq.push_back('{mode[0], 1'b0, 1'b0, "R9 disable"});
        @(posedge clk); #1;
    endtask

    // R7 R9: while disabled, a mode write shows as the new idle level.
    task automatic idle_mode(int m);
        @(posedge clk); #1;
        wr_mode = 1; mode_data = m[0];
        @(posedge clk); #1;
        wr_mode = 0;
        @(posedge clk); #1;
        sbq.push_back('{m[0], 1'b0, 1'b1, "R7 R9 idle mode"});
        @(posedge clk); #1;
    endtask

    initial begin
        rst = 1; en = 0;
        wr_presc = 0; wr_period = 0; wr_compare = 0; wr_mode = 0; wr_align = 0;
        presc_data = '0; period_data = '0; compare_data = '0;
        mode_data = 0; align_data = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        sbq.push_back('{1'b0, 1'b0, 1'b1, "R9 reset"});
        @(posedge clk); #1;

        run(0, 4, 2, 0, 0, 30, -1, 0, "R2 R3 R8 edge");
        run(2, 3, 1, 1, 0, 60, -1, 0, "R1 R4 R8 prescaled");
        run(0, 5, 0, 0, 0, 20, -1, 0, "R5 zero duty");
        run(1, 5, 6, 0, 0, 30, -1, 0, "R5 full duty");
        run(0, 5, 0, 1, 0, 12, -1, 0, "R5 R4 inverted zero");
        run(0, 3, 2, 0, 1, 40, -1, 0, "R6 R8 center");
        run(1, 1, 1, 1, 1, 30, -1, 0, "R6 R1 center short");
        run(0, 0, 1, 0, 1, 10, -1, 0, "R6 center zero period");
        run(1, 4, 1, 0, 0, 60, 7, 3, "R7 edge compare update");
        run(0, 4, 3, 0, 1, 60, 5, 1, "R7 center compare update");
        idle_mode(1);
        idle_mode(0);

        repeat (2) @(posedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule